// File: doc/BRIEF.md
# Fractional M/N Audio Clock Divider

This block derives an audio-interface clock from its own input clock. The output runs at the input frequency times M over N, where M and N are integers held in a single 32-bit control word. The output is a square wave that changes level on input-clock edges. A one-cycle tick marks every level change, so logic in the input domain can use it as a clock enable. The ratio is a true fraction, so sample rates that are not integer divisions of the parent can be reached with bounded jitter.

Each input cycle, a phase accumulator adds twice M. When the sum reaches N, the output changes level and N is subtracted from the sum. Software writes the control word through a plain write port and reads it back on a parallel read bus.

The word also carries a two-bit parent-source selector. The block does not act on this selector; it only stores it and drives it out to the clock multiplexer outside. Settings that would need more than one output edge per input cycle are refused: the divider stops and a sticky error flag is raised.

Top module: `frac_mn_clkdiv`

## Requirements
- R1: Synchronous active-high reset clears the control word to zero, drives the divided clock and tick low, and clears the error flag.
- R2: A write stores all 32 bits exactly as given, whether or not the settings are legal. The read bus always shows the stored word.
- R3: Bits 31:30 of the control word are driven on the source-select output and take effect the cycle after the write.
- R4: Bit 29 is the run enable. While it is clear, the divided clock keeps its level.
- R5: M sits in bits 28:20 and N in bits 19:0. After the divider starts from a cleared accumulator, the number of output level changes after c input cycles equals floor(c*2M/N). The average output frequency is therefore f_in*M/N.
- R6: With M = 1 and an even N, the output changes level exactly every N/2 input cycles, which is an exact integer division by N.
- R7: A setting is legal only when M >= 1, N >= 2 and N >= 2M. While the stored setting is illegal, the output holds and no tick is produced.
- R8: Any write of an illegal M/N pair sets the error output, which stays set until reset.
- R9: When the divider goes from stopped to running, the accumulator restarts from zero, so the phase of the output is the same on every start.
- R10: An M or N written while running is adopted at the next level change. If it differs from the active pair, the accumulator restarts from zero at that change.
- R11: The tick output is high for exactly one cycle after each level change of the divided clock, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (parent) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Stored control word |
| src_sel_o | output | 2 | Parent clock source selector |
| div_clk_o | output | 1 | Divided clock level |
| div_tick_o | output | 1 | One-cycle pulse after each level change |
| cfg_err_o | output | 1 | Sticky illegal-setting flag |

## Verification
A write is taken at the first rising edge after the strobe, and the read bus and selector are compared at the following falling edge. When a start write lands on edge E0, the accumulator first advances on E1. The bench therefore counts cycle c as the c-th edge after E0 and compares the level changes seen by the falling edge after that edge with floor(c*2M/N). For a mid-run change, the write edge still uses the old pair, so the expected toggle cycles are built from the old schedule up to the first level change and from the new one after it. Hold and error checks are sampled from the falling edge after the write edge onward.

// File: rtl/frac_mn_clkdiv.sv
module frac_mn_clkdiv #(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int SEL_W = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [SEL_W+M_W+N_W:0]             cfg_wdata,
  output logic [SEL_W+M_W+N_W:0]             cfg_rdata,
  output logic [SEL_W-1:0]                   src_sel_o,
  output logic                               div_clk_o,
  output logic                               div_tick_o,
  output logic                               cfg_err_o
);
  localparam int DW    = SEL_W + M_W + N_W + 1;
  localparam int EN_B  = M_W + N_W;
  localparam int M_LO  = N_W;
  localparam int SEL_LO = EN_B + 1;
  localparam int PADW  = N_W - M_W;

  logic [DW-1:0]  ctrl_q;
  logic [M_W-1:0] m_act_q;
  logic [N_W-1:0] n_act_q;
  logic [N_W-1:0] acc_q;
  logic           run_q;

  function automatic logic legal(input logic [M_W-1:0] m, input logic [N_W-1:0] n);
    logic [N_W-1:0] two_m;
    two_m = {{(PADW-1){1'b0}}, m, 1'b0};
    return (m != '0) && (n >= N_W'(2)) && (n >= two_m);
  endfunction

  wire [M_W-1:0] reg_m  = ctrl_q[M_LO +: M_W];
  wire [N_W-1:0] reg_n  = ctrl_q[0 +: N_W];
  wire           reg_en = ctrl_q[EN_B];
  wire           reg_ok = legal(reg_m, reg_n);
  wire           run    = reg_en && reg_ok;
  wire           start  = run && !run_q;

  wire [M_W-1:0] m_use    = start ? reg_m : m_act_q;
  wire [N_W-1:0] n_use    = start ? reg_n : n_act_q;
  wire [N_W-1:0] acc_base = start ? '0 : acc_q;
  wire [N_W:0]   sum      = {1'b0, acc_base} + {{PADW{1'b0}}, m_use, 1'b0};
  wire           wrap     = sum >= {1'b0, n_use};
  wire [N_W:0]   rem      = sum - {1'b0, n_use};
  wire           new_pair = (reg_m != m_use) || (reg_n != n_use);
  wire           wr_bad   = !legal(cfg_wdata[M_LO +: M_W], cfg_wdata[0 +: N_W]);

  assign cfg_rdata = ctrl_q;
  assign src_sel_o = ctrl_q[SEL_LO +: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      m_act_q    <= '0;
      n_act_q    <= '0;
      acc_q      <= '0;
      run_q      <= 1'b0;
      div_clk_o  <= 1'b0;
      div_tick_o <= 1'b0;
      cfg_err_o  <= 1'b0;
    end else begin
      run_q      <= run;
      div_tick_o <= 1'b0;
      if (cfg_we) begin
        ctrl_q <= cfg_wdata;
        if (wr_bad) cfg_err_o <= 1'b1;
      end
      if (run) begin
        if (wrap) begin
          div_clk_o  <= !div_clk_o;
          div_tick_o <= 1'b1;
          m_act_q    <= reg_m;
          n_act_q    <= reg_n;
          acc_q      <= new_pair ? '0 : rem[N_W-1:0];
        end else begin
          m_act_q <= m_use;
          n_act_q <= n_use;
          acc_q   <= sum[N_W-1:0];
        end
      end
    end
  end

  p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (acc_q < n_act_q));
  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[EN_B] |=> $stable(div_clk_o));
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !reg_ok |=> ($stable(div_clk_o) && !div_tick_o));
  p_sel_follow_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (src_sel_o == $past(cfg_wdata[SEL_LO +: SEL_W])));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o);
  p_tick_edge_r11: assert property (@(posedge clk) disable iff (rst)
    div_tick_o |-> (div_clk_o != $past(div_clk_o)));
endmodule

// File: tb/frac_mn_clkdiv_bench.sv
module frac_mn_clkdiv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  src_sel_o;
  logic        div_clk_o, div_tick_o, cfg_err_o;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_mn_clkdiv u_frac_mn_clkdiv (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_sel_o(src_sel_o), .div_clk_o(div_clk_o),
    .div_tick_o(div_tick_o), .cfg_err_o(cfg_err_o));

  function automatic logic [31:0] mk(input logic [1:0] sel, input logic en,
                                     input int m, input int n);
    return {sel, en, m[8:0], n[19:0]};
  endfunction

  function automatic longint exp_toggles(input longint c, input longint m, input longint n);
    return (c * 2 * m) / n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_count(input logic [1:0] sel, input int m, input int n, input int w);
    int tog = 0;
    int tick_bad = 0;
    logic prev;
    wr(mk(sel, 1'b0, m, n));
    wr(mk(sel, 1'b1, m, n));
    check("R2 readback", cfg_rdata, mk(sel, 1'b1, m, n));
    check("R3 select", src_sel_o, sel);
    prev = div_clk_o;
    for (int c = 1; c <= w; c++) begin
      @(negedge clk);
      if (div_clk_o != prev) tog++;
      if (div_tick_o != (div_clk_o != prev)) tick_bad++;
      prev = div_clk_o;
    end
    check("R5 toggle count", tog, exp_toggles(w, m, n));
    check("R11 tick mismatches", tick_bad, 0);
    check("R8 no error on legal", cfg_err_o, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic prev;
    seed_dummy = $urandom(32'd20201126);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata reset", cfg_rdata, 0);
    check("R1 clk reset", div_clk_o, 0);
    check("R1 tick reset", div_tick_o, 0);
    check("R1 err reset", cfg_err_o, 0);

    // directed ratios, R9 phase restart covered by the stop/start in each run
    run_count(2'd1, 1, 2, 500);
    run_count(2'd2, 511, 1022, 500);
    run_count(2'd3, 1, 1048575, 500);
    run_count(2'd0, 3, 7, 700);
    run_count(2'd0, 3, 7, 700);   // R9 same count on a second start

    // R6 exact integer division: M=1, N=6 toggles every 3 cycles
    wr(mk(2'd0, 1'b0, 1, 6));
    wr(mk(2'd0, 1'b1, 1, 6));
    prev = div_clk_o;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      check("R6 exact period", (div_clk_o != prev), ((c % 3) == 0));
      prev = div_clk_o;
    end

    // random legal pairs
    for (int k = 0; k < 10; k++) begin
      int m, n;
      m = 1 + int'($urandom % 511);
      n = 2 * m + int'($urandom % 3000);
      run_count(2'($urandom % 4), m, n, 3000);
    end

    // R10 mid-run change: M=1,N=8 then M=1,N=4 written before cycle 6
    wr(mk(2'd0, 1'b0, 1, 8));
    wr(mk(2'd0, 1'b1, 1, 8));
    prev = div_clk_o;
    for (int c = 1; c <= 14; c++) begin
      if (c == 6) begin
        cfg_we = 1'b1;
        cfg_wdata = mk(2'd0, 1'b1, 1, 4);
      end
      @(negedge clk);
      if (c == 6) cfg_we = 1'b0;
      check("R10 adopt at toggle", (div_clk_o != prev),
            (c == 4 || c == 8 || c == 10 || c == 12 || c == 14));
      prev = div_clk_o;
    end

    // R4 disable holds level
    wr(mk(2'd2, 1'b0, 1, 4));
    @(negedge clk);
    prev = div_clk_o;
    begin
      int moved = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (div_clk_o != prev || div_tick_o) moved++;
      end
      check("R4 held while disabled", moved, 0);
    end

    // R7 / R8 illegal settings
    wr(mk(2'd1, 1'b1, 3, 5));
    check("R2 illegal stored", cfg_rdata, mk(2'd1, 1'b1, 3, 5));
    check("R8 error set", cfg_err_o, 1);
    prev = div_clk_o;
    begin
      int moved = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (div_clk_o != prev || div_tick_o) moved++;
      end
      check("R7 hold on N<2M", moved, 0);
    end
    wr(mk(2'd1, 1'b1, 0, 10));
    check("R7 M=0 stored", cfg_rdata, mk(2'd1, 1'b1, 0, 10));
    begin
      int moved = 0;
      prev = div_clk_o;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (div_clk_o != prev) moved++;
      end
      check("R7 hold on M=0", moved, 0);
    end
    wr(mk(2'd1, 1'b1, 1, 4));
    check("R8 error sticky after legal write", cfg_err_o, 1);
    begin
      int tog = 0;
      prev = div_clk_o;
      for (int c = 1; c <= 40; c++) begin
        @(negedge clk);
        if (div_clk_o != prev) tog++;
        prev = div_clk_o;
      end
      check("R7 runs again once legal", tog, 20);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule